// File: doc/BRIEF.md
# Five-Wire Serial Register Slave

This block is the device-side end of a five-line serial control port. A host drives a serial clock, a command data line and an active-low select. The block returns a reply data line and an active-low interrupt request. Inside a select window the host first clocks in an 8-bit register address, most significant bit first. The address decides what follows. For a write address, one or two 8-bit data bursts come in on the command line. For a read address, one or two 8-bit reply bursts go out on the reply line. All traffic is grouped in 8-bit bursts, and only one register is touched per window.

The serial lines are sampled into the system clock domain by two-flop synchronisers, and edges of the serial clock are detected there. Towards the rest of the device the block presents a plain register bus. It has an address, write data, a write strobe, a read strobe and read data. That bus has no back-pressure. A write strobe is one system clock wide and must be accepted in that cycle. After a read strobe, the read data must be valid on the next system clock and held while the address is stable. The interrupt request pin is the registered, inverted copy of a device-side request input.

Address encoding: bit 7 set means read and clear means write. Bit 6 set means two bursts (16-bit value) and clear means one burst (8-bit value).

Top module: `ser_reg_slave`

## Requirements
- R1: After reset, reply_out and irq_n are high and reg_we and reg_re are low.
- R2: The first 8 command bits of a window form the address, taken MSB first. For a write address with bit 6 clear, one data burst follows. After its last bit, reg_we pulses once, with reg_addr set to the address and reg_wdata set to the byte in bits 7:0 and zeros above.
- R3: For a write address with bit 6 set, two bursts follow. The first burst becomes reg_wdata[15:8] and the second becomes reg_wdata[7:0]. reg_we pulses once, after the 16th data bit.
- R4: For a read address, reg_re pulses once after the 8th address bit. With bit 6 clear, reg_rdata[7:0] is sent on reply_out MSB first, one bit per serial clock period, and each bit is valid before the rising serial clock edge on which the host samples it.
- R5: For a read address with bit 6 set, the reply is reg_rdata[15:8] followed by reg_rdata[7:0], MSB first.
- R6: If select rises before the last data bit of a write, no write strobe is issued. The next window starts a new address.
- R7: Once the register of a window has been written or fully read, further bursts in that window are ignored. They cause no strobe.
- R8: reply_out is high whenever select is high, or no reply is pending (during the address and during writes).
- R9: irq_n is low one system clock after irq_src is high, and high one clock after it is low.
- R10: reg_we and reg_re are each high for exactly one system clock per transaction, and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock (asynchronous) |
| csn | input | 1 | Active-low select from host |
| cmd_in | input | 1 | Command data from host |
| reply_out | output | 1 | Reply data to host, idle high |
| irq_n | output | 1 | Active-low interrupt request to host |
| irq_src | input | 1 | Device-side interrupt request, active high |
| reg_addr | output | 8 | Register address on the register bus |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_re | output | 1 | One-clock read strobe |
| reg_rdata | input | 16 | Register read data, valid the clock after reg_re |

## Verification
The assertions take for granted that the serial clock is slow against the system clock. Each serial clock level must last several system clocks, so every rising edge survives synchronisation and a read reply is loaded before the next sampling edge. They also assume that select and command data change only while the serial clock is low. The bench drives each serial clock half period as eight system clocks. It changes command data and select only in the low phase, and it samples reply_out just before each rising serial edge, which keeps every transfer inside those rules.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int BURST_W = 8;
  localparam int MAX_BURSTS = 2;
  localparam int DATA_W = BURST_W * MAX_BURSTS;

  typedef enum logic [1:0] {
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_DONE
  } srs_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d_async[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/srs_engine.sv
module srs_engine
  import srs_pkg::*;
#(
  parameter int BW = BURST_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          cmd_s,
  output logic          reply,
  output logic [BW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(DW);
  localparam int RD_BIT = BW - 1;
  localparam int TWO_BIT = BW - 2;

  srs_state_e   state;
  logic         sclk_d;
  logic         rise;
  logic         cs_act;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic         two;
  logic         loaded;
  logic         rd_cap;
  logic [BW-2:0] ash;
  logic [DW-2:0] wsh;
  logic [DW-1:0] tx;

  assign rise   = sclk_s & ~sclk_d;
  assign cs_act = ~csn_s;
  assign last   = two ? CNT_W'(DW - 1) : CNT_W'(BW - 1);
  assign reply  = (state == ST_RD && loaded) ? tx[DW-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ADDR;
      sclk_d    <= 1'b0;
      cnt       <= '0;
      two       <= 1'b0;
      loaded    <= 1'b0;
      rd_cap    <= 1'b0;
      ash       <= '0;
      wsh       <= '0;
      tx        <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      rd_cap <= reg_re;
      if (!cs_act) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        loaded <= 1'b0;
      end else begin
        if (rd_cap && state == ST_RD) begin
          tx     <= two ? reg_rdata : {reg_rdata[BW-1:0], {(DW-BW){1'b0}}};
          loaded <= 1'b1;
        end
        if (rise) begin
          case (state)
            ST_ADDR: begin
              ash <= {ash[BW-3:0], cmd_s};
              if (cnt == CNT_W'(BW - 1)) begin
                reg_addr <= {ash, cmd_s};
                two      <= (TWO_BIT == 0) ? cmd_s : ash[TWO_BIT-1];
                cnt      <= '0;
                if (ash[RD_BIT-1]) begin
                  state  <= ST_RD;
                  reg_re <= 1'b1;
                end else begin
                  state  <= ST_WR;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_WR: begin
              wsh <= {wsh[DW-3:0], cmd_s};
              if (cnt == last) begin
                reg_we    <= 1'b1;
                reg_wdata <= two ? {wsh, cmd_s}
                                 : {{(DW-BW){1'b0}}, wsh[BW-2:0], cmd_s};
                state     <= ST_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_RD: begin
              if (loaded) tx <= {tx[DW-2:0], 1'b1};
              if (cnt == last) state <= ST_DONE;
              else             cnt   <= cnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_we_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_re_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  p_we_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cs_act));
  p_re_enters_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (state == ST_RD || !cs_act));
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state == ST_DONE)) |-> (!reg_we && !reg_re));
  p_reply_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> reply);
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
  import srs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              cmd_in,
  output logic              reply_out,
  output logic              irq_n,
  input  logic              irq_src,
  output logic [BURST_W-1:0] reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0]  reg_rdata
);
  logic [2:0] sync_q;

  srs_sync #(
    .WIDTH  (3),
    .STAGES (2),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({cmd_in, csn, sclk}),
    .q      (sync_q)
  );

  srs_engine #(
    .BW(BURST_W),
    .DW(DATA_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sync_q[0]),
    .csn_s    (sync_q[1]),
    .cmd_s    (sync_q[2]),
    .reply    (reply_out),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~irq_src;
  end

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src |=> !irq_n);
  p_irq_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_src |=> irq_n);
endmodule

// File: tb/ser_reg_slave_tb.sv
module ser_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0]  a;
    logic [15:0] d;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h12, 16'h00A7},
    '{8'h45, 16'hBEEF},
    '{8'h83, 16'h0000},
    '{8'hC9, 16'h0000},
    '{8'h3F, 16'h005C},
    '{8'hFE, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        csn = 1'b1;
  logic        cmd_in = 1'b0;
  logic        reply_out;
  logic        irq_n;
  logic        irq_src = 1'b0;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [15:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  int strobe_err = 0;
  logic        prev_we = 1'b0;
  logic        prev_re = 1'b0;
  logic [7:0]  cap_addr = '0;
  logic [15:0] cap_data = '0;
  logic        reply_ones;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(input logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  assign reg_rdata = model(reg_addr);

  ser_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .cmd_in(cmd_in),
    .reply_out(reply_out), .irq_n(irq_n), .irq_src(irq_src),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    prev_we <= reg_we;
    prev_re <= reg_re;
    if (reg_we) begin
      we_cnt   <= we_cnt + 1;
      cap_addr <= reg_addr;
      cap_data <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
    if ((reg_we && prev_we) || (reg_re && prev_re) || (reg_we && reg_re))
      strobe_err <= strobe_err + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    @(negedge clk);
    sclk = 1'b0;
    cmd_in = b;
    repeat (HALF) @(negedge clk);
    r = reply_out;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic open_win();
    @(negedge clk);
    sclk = 1'b0;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, output logic [15:0] rx);
    logic r;
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_xfer(v[i], r);
      rx = {rx[14:0], r};
    end
  endtask

  initial begin
    int we0, re0;
    logic [15:0] rx;
    logic [15:0] dummy;
    int nb;

    repeat (3) @(negedge clk);
    check("R1 reply idle", reply_out, 1);
    check("R1 irq_n idle", irq_n, 1);
    check("R1 strobes low", {reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      we0 = we_cnt;
      re0 = re_cnt;
      nb = VECS[k].a[6] ? 16 : 8;
      open_win();
      send_bits({8'h00, VECS[k].a}, 8, dummy);
      send_bits(VECS[k].d, nb, rx);
      close_win();
      if (!VECS[k].a[7]) begin
        check(VECS[k].a[6] ? "R3 write count" : "R2 write count", we_cnt - we0, 1);
        check("R2 write addr", cap_addr, VECS[k].a);
        check(VECS[k].a[6] ? "R3 write data" : "R2 write data", cap_data,
              VECS[k].a[6] ? VECS[k].d : {8'h00, VECS[k].d[7:0]});
        check("R8 reply idle on write", rx, 16'h0000 | ((1 << nb) - 1));
      end else begin
        check("R4 read strobe count", re_cnt - re0, 1);
        check(VECS[k].a[6] ? "R5 reply two bursts" : "R4 reply one burst", rx,
              VECS[k].a[6] ? model(VECS[k].a) : {8'h00, model(VECS[k].a)[7:0]});
        check("R10 no write on read", we_cnt - we0, 0);
      end
    end

    we0 = we_cnt;
    open_win();
    send_bits(16'h0045, 8, dummy);
    send_bits(16'h00AB, 8, dummy);
    send_bits(16'h0019, 5, dummy);
    close_win();
    check("R6 abort no strobe", we_cnt - we0, 0);
    open_win();
    send_bits(16'h0012, 8, dummy);
    send_bits(16'h0066, 8, dummy);
    close_win();
    check("R6 recover after abort", {cap_addr, cap_data}, {8'h12, 16'h0066});

    we0 = we_cnt;
    re0 = re_cnt;
    open_win();
    send_bits(16'h0012, 8, dummy);
    send_bits(16'h0033, 8, dummy);
    send_bits(16'h0020, 8, dummy);
    send_bits(16'h00FF, 8, dummy);
    send_bits(16'h0083, 8, rx);
    close_win();
    check("R7 one strobe per window", we_cnt - we0, 1);
    check("R7 second address ignored", {cap_addr, cap_data}, {8'h12, 16'h0033});
    check("R7 no read strobe", re_cnt - re0, 0);
    check("R8 reply idle after done", rx[7:0], 8'hFF);

    repeat (2) @(negedge clk);
    reply_ones = reply_out;
    check("R8 reply high when deselected", reply_ones, 1);

    irq_src = 1'b1;
    @(negedge clk);
    check("R9 irq asserted", irq_n, 0);
    irq_src = 1'b0;
    @(negedge clk);
    check("R9 irq released", irq_n, 1);

    check("R10 strobe width and overlap", strobe_err, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule